// File: doc/BRIEF.md
# VGA I/O Port Register Emulator

This block is a byte-wide I/O slave. It takes the place of the standard VGA register ports in the 0x3C0 to 0x3DA window, so that video firmware can set up display modes on a system that has no real VGA hardware. It holds four indexed register banks (attribute, sequencer, graphics and CRT controller), the miscellaneous output register, the DAC pixel mask, the DAC read and write pointers with their palette memory, and an input status byte. It generates no video timing and drives no pixels.

A host drives a port address, write data and a write or read strobe, one access per cycle. A word write (`wr_wide` set) is split into two byte writes: the low byte goes to the addressed port on that clock edge, and the high byte goes to the next port up on the following edge. The host leaves the cycle after a word write idle. Read data is registered: `rd_data` takes the value of the port at the edge that samples `rd_en` and holds it until the next read. Side effects of reads, such as the flip-flop toggle, the status toggle and the palette pointer advance, happen at that same edge.

Top module: `vga_port_emu`

## Requirements
- R1: After reset every register, index, pointer, palette byte, the status byte and the attribute flip-flop are 0, and `rd_data` is 0.
- R2: Every access to port 0x3C0, read or write, toggles the attribute flip-flop. When the flip-flop is 0 the port reads and writes the attribute index. When it is 1 the port reads or writes the attribute entry at that index. Port 0x3C1 reads the entry at the index and is read-only. An index of 21 or more makes reads return 0xFF and makes entry writes have no effect, and the toggle still happens.
- R3: A read of 0x3DA returns the status byte, clears the attribute flip-flop, and then XORs the status byte with 0x09, so successive reads after reset return 0x00, 0x09, 0x00 and so on.
- R4: A write of value v to 0x3C7 (read pointer) or 0x3C8 (write pointer) sets that pointer to 3*v. A read of either port returns the low 8 bits of the pointer.
- R5: A write to 0x3C9 stores the byte in the palette at the write pointer. A read of 0x3C9 returns the palette byte at the read pointer. Each access then advances its pointer by one. Once a pointer reaches 768, 0x3C9 writes have no effect, reads return 0xFF, and the pointer stays at 768.
- R6: The CRTC index port 0x3D4 and data port 0x3D5 respond only while bit 0 of the miscellaneous output register is 1. Otherwise writes have no effect and reads return 0xFF.
- R7: The index/data pairs 0x3C4/0x3C5 (5 sequencer entries), 0x3CE/0x3CF (9 graphics entries) and 0x3D4/0x3D5 (25 CRTC entries) store a full 8-bit index and read it back. A data port accesses the entry only when the index is below the bank size. Otherwise the data write has no effect and the data read returns 0xFF.
- R8: The miscellaneous output register is written at 0x3C2 and read at 0x3CC. The DAC mask reads and writes at 0x3C6.
- R9: A word write to port p applies its low byte to p at the strobe edge and its high byte to p+1 on the next edge, each with the full per-port behaviour, including the 0x3C0 flip-flop.
- R10: Reads of ports with no read function (0x3C2, 0x3C3, any port outside the window) return 0xFF. Writes to ports with no write function (0x3C1, 0x3CC) have no effect.
- R11: `rd_data` changes only at an edge that samples `rd_en`. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 16 | I/O port address of the access |
| wr_data | input | 16 | Write data; bits 7:0 for a byte write, both bytes for a word write |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | With wr_en, split the write into two byte writes (p, then p+1) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
The bench walks the attribute port through every order of reads and writes. It clears the flip-flop with a status read in the middle of a pair, then checks that the next access hits the index. A design that toggled only on writes, or that missed the clear, would return a data byte where the index belongs. It drives both DAC pointers up to the palette end from a scaled start of 765, where a design that wrapped or went on counting would return stale bytes instead of 0xFF, or a wrong pointer low byte. It also checks the out-of-range indices just past each bank size, CRTC access with the enable bit clear, and word writes that land across a flip-flop toggle. Each of these fails as a wrong read value at the ports.

// File: rtl/vga_emu_pkg.sv
package vga_emu_pkg;
  localparam int BYTE_W = 8;

  // Port map of the emulated window
  localparam logic [15:0] P_ATTR   = 16'h03C0;
  localparam logic [15:0] P_ATTRRD = 16'h03C1;
  localparam logic [15:0] P_MISCW  = 16'h03C2;
  localparam logic [15:0] P_SEQI   = 16'h03C4;
  localparam logic [15:0] P_SEQD   = 16'h03C5;
  localparam logic [15:0] P_MASK   = 16'h03C6;
  localparam logic [15:0] P_DACR   = 16'h03C7;
  localparam logic [15:0] P_DACW   = 16'h03C8;
  localparam logic [15:0] P_PAL    = 16'h03C9;
  localparam logic [15:0] P_MISCR  = 16'h03CC;
  localparam logic [15:0] P_GFXI   = 16'h03CE;
  localparam logic [15:0] P_GFXD   = 16'h03CF;
  localparam logic [15:0] P_CRTI   = 16'h03D4;
  localparam logic [15:0] P_CRTD   = 16'h03D5;
  localparam logic [15:0] P_STAT   = 16'h03DA;

  localparam logic [BYTE_W-1:0] STAT_FLIP = 8'h09;
  localparam logic [BYTE_W-1:0] NO_DATA   = 8'hFF;

  // Pointer value for a DAC pointer write: three bytes per colour
  function automatic logic [15:0] dac_scale(input logic [BYTE_W-1:0] v);
    return {8'h00, v} + {7'h00, v, 1'b0};
  endfunction

  // True when an index selects an entry of a bank of the given size
  function automatic logic idx_ok(input logic [BYTE_W-1:0] i, input int depth);
    return int'(i) < depth;
  endfunction
endpackage

// File: rtl/vga_wide_split.sv
module vga_wide_split
  import vga_emu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         host_addr,
  input  logic [2*BYTE_W-1:0]   host_wdata,
  input  logic                  host_we,
  input  logic                  host_wide,
  input  logic                  host_re,
  output logic [AW-1:0]         bus_addr,
  output logic [BYTE_W-1:0]     bus_wdata,
  output logic                  bus_we
);
  logic              pend;
  logic [AW-1:0]     pend_addr;
  logic [BYTE_W-1:0] pend_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pend      <= host_we && host_wide;
      pend_addr <= host_addr + AW'(1);
      pend_data <= host_wdata[2*BYTE_W-1:BYTE_W];
    end
  end

  always_comb begin
    if (pend) begin
      bus_addr  = pend_addr;
      bus_wdata = pend_data;
      bus_we    = 1'b1;
    end else begin
      bus_addr  = host_addr;
      bus_wdata = host_wdata[BYTE_W-1:0];
      bus_we    = host_we;
    end
  end

  AST_SPLIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !host_we && !host_re);  // R9
  AST_SECOND_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_wide |=> bus_we && bus_addr == $past(host_addr) + AW'(1)
                             && bus_wdata == $past(host_wdata[2*BYTE_W-1:BYTE_W]));  // R9
endmodule

// File: rtl/vga_idx_bank.sv
module vga_idx_bank
  import vga_emu_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] idx,
  output logic              dat_hit,
  output logic [BYTE_W-1:0] dat_q
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [IW-1:0]     sel;

  assign sel     = idx[IW-1:0];
  assign dat_hit = idx_ok(idx, DEPTH);
  assign dat_q   = dat_hit ? mem[sel] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      if (idx_we) idx <= wdata;
      if (dat_we && dat_hit) mem[sel] <= wdata;
    end
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx));  // R7
  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we && !dat_hit && !idx_we |=> $stable(dat_q));  // R7
endmodule

// File: rtl/vga_dac.sv
module vga_dac
  import vga_emu_pkg::*;
#(
  parameter int PAL_N = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rptr_we,
  input  logic              wptr_we,
  input  logic              pal_we,
  input  logic              pal_re,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PW-1:0]     rptr,
  output logic [PW-1:0]     wptr,
  output logic              r_ok,
  output logic [BYTE_W-1:0] pal_q
);
  localparam int PW = $clog2(PAL_N + 1);

  logic [BYTE_W-1:0] pal [PAL_N];
  logic              w_ok;

  assign r_ok  = int'(rptr) < PAL_N;
  assign w_ok  = int'(wptr) < PAL_N;
  assign pal_q = r_ok ? pal[rptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      for (int k = 0; k < PAL_N; k++) pal[k] <= '0;
    end else begin
      if (rptr_we)            rptr <= PW'(dac_scale(wdata));
      else if (pal_re && r_ok) rptr <= rptr + PW'(1);
      if (wptr_we)            wptr <= PW'(dac_scale(wdata));
      else if (pal_we && w_ok) begin
        pal[wptr] <= wdata;
        wptr      <= wptr + PW'(1);
      end
    end
  end

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we && w_ok && !wptr_we |=> wptr == $past(wptr) + PW'(1));  // R5
  AST_RPTR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    pal_re && !r_ok && !rptr_we |=> $stable(rptr));  // R5
endmodule

// File: rtl/vga_port_emu.sv
module vga_port_emu
  import vga_emu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ATTR_N = 21,
  parameter int SEQ_N  = 5,
  parameter int GFX_N  = 9,
  parameter int CRT_N  = 25,
  parameter int PAL_N  = 768
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   port_addr,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic                wr_en,
  input  logic                wr_wide,
  input  logic                rd_en,
  output logic [BYTE_W-1:0]   rd_data
);
  localparam int NBANK = 4;
  localparam int BANK_N [NBANK] = '{ATTR_N, SEQ_N, GFX_N, CRT_N};
  localparam int B_ATTR = 0, B_SEQ = 1, B_GFX = 2, B_CRT = 3;
  localparam int PW = $clog2(PAL_N + 1);

  // Effective byte bus after word splitting
  logic [ADDR_W-1:0] bus_addr;
  logic [BYTE_W-1:0] bus_wdata;
  logic              bus_we;

  vga_wide_split #(.AW(ADDR_W)) i_split (
    .clk(clk), .rst_n(rst_n),
    .host_addr(port_addr), .host_wdata(wr_data), .host_we(wr_en),
    .host_wide(wr_wide), .host_re(rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we)
  );

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [15:0] p);
    return a == ADDR_W'(p);
  endfunction

  // Plain registers
  logic [BYTE_W-1:0] misc_q, mask_q, stat_q;
  logic              attr_ff;
  logic              crt_open;

  // Named events
  logic attr_access, stat_read;
  assign crt_open    = misc_q[0];
  assign attr_access = (bus_we || rd_en) && at(bus_addr, P_ATTR);
  assign stat_read   = rd_en && at(port_addr, P_STAT);

  // Indexed banks
  logic [NBANK-1:0]             bk_idx_we, bk_dat_we, bk_hit;
  logic [NBANK-1:0][BYTE_W-1:0] bk_idx, bk_q;

  always_comb begin
    bk_idx_we[B_ATTR] = bus_we && at(bus_addr, P_ATTR) && !attr_ff;
    bk_dat_we[B_ATTR] = bus_we && at(bus_addr, P_ATTR) &&  attr_ff;
    bk_idx_we[B_SEQ]  = bus_we && at(bus_addr, P_SEQI);
    bk_dat_we[B_SEQ]  = bus_we && at(bus_addr, P_SEQD);
    bk_idx_we[B_GFX]  = bus_we && at(bus_addr, P_GFXI);
    bk_dat_we[B_GFX]  = bus_we && at(bus_addr, P_GFXD);
    bk_idx_we[B_CRT]  = bus_we && at(bus_addr, P_CRTI) && crt_open;
    bk_dat_we[B_CRT]  = bus_we && at(bus_addr, P_CRTD) && crt_open;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    vga_idx_bank #(.DEPTH(BANK_N[g])) i_bank (
      .clk(clk), .rst_n(rst_n),
      .idx_we(bk_idx_we[g]), .dat_we(bk_dat_we[g]), .wdata(bus_wdata),
      .idx(bk_idx[g]), .dat_hit(bk_hit[g]), .dat_q(bk_q[g])
    );
  end

  // DAC pointers and palette
  logic [PW-1:0]     dac_rptr, dac_wptr;
  logic              dac_rok;
  logic [BYTE_W-1:0] dac_q;
  logic              pal_rd;

  assign pal_rd = rd_en && at(port_addr, P_PAL);

  vga_dac #(.PAL_N(PAL_N)) i_dac (
    .clk(clk), .rst_n(rst_n),
    .rptr_we(bus_we && at(bus_addr, P_DACR)),
    .wptr_we(bus_we && at(bus_addr, P_DACW)),
    .pal_we (bus_we && at(bus_addr, P_PAL)),
    .pal_re (pal_rd),
    .wdata(bus_wdata),
    .rptr(dac_rptr), .wptr(dac_wptr), .r_ok(dac_rok), .pal_q(dac_q)
  );

  // Single-byte registers, flip-flop and status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q  <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      attr_ff <= 1'b0;
    end else begin
      if (bus_we && at(bus_addr, P_MISCW)) misc_q <= bus_wdata;
      if (bus_we && at(bus_addr, P_MASK))  mask_q <= bus_wdata;
      if (stat_read) begin
        stat_q  <= stat_q ^ STAT_FLIP;
        attr_ff <= 1'b0;
      end else if (attr_access) begin
        attr_ff <= ~attr_ff;
      end
    end
  end

  // Read selection
  logic [BYTE_W-1:0] rd_sel;

  function automatic logic [BYTE_W-1:0] gate(input logic ok, input logic [BYTE_W-1:0] v);
    return ok ? v : NO_DATA;
  endfunction

  always_comb begin
    rd_sel = NO_DATA;
    if      (at(port_addr, P_ATTR))   rd_sel = attr_ff ? gate(bk_hit[B_ATTR], bk_q[B_ATTR])
                                                      : bk_idx[B_ATTR];
    else if (at(port_addr, P_ATTRRD)) rd_sel = gate(bk_hit[B_ATTR], bk_q[B_ATTR]);
    else if (at(port_addr, P_SEQI))   rd_sel = bk_idx[B_SEQ];
    else if (at(port_addr, P_SEQD))   rd_sel = gate(bk_hit[B_SEQ], bk_q[B_SEQ]);
    else if (at(port_addr, P_MASK))   rd_sel = mask_q;
    else if (at(port_addr, P_DACR))   rd_sel = dac_rptr[BYTE_W-1:0];
    else if (at(port_addr, P_DACW))   rd_sel = dac_wptr[BYTE_W-1:0];
    else if (at(port_addr, P_PAL))    rd_sel = gate(dac_rok, dac_q);
    else if (at(port_addr, P_MISCR))  rd_sel = misc_q;
    else if (at(port_addr, P_GFXI))   rd_sel = bk_idx[B_GFX];
    else if (at(port_addr, P_GFXD))   rd_sel = gate(bk_hit[B_GFX], bk_q[B_GFX]);
    else if (at(port_addr, P_CRTI))   rd_sel = gate(crt_open, bk_idx[B_CRT]);
    else if (at(port_addr, P_CRTD))   rd_sel = gate(crt_open && bk_hit[B_CRT], bk_q[B_CRT]);
    else if (at(port_addr, P_STAT))   rd_sel = stat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));  // R9
  AST_FLOP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    attr_access |=> attr_ff != $past(attr_ff));  // R2
  AST_FLOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_read |=> !attr_ff);  // R3
  AST_STAT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    stat_read |=> rd_data == $past(stat_q));  // R3
  AST_CRT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !crt_open && at(bus_addr, P_CRTI) |=> $stable(bk_idx[B_CRT]));  // R6
  AST_PTR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dac_rptr) <= PAL_N && int'(dac_wptr) <= PAL_N);  // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));  // R11
endmodule

// File: tb/test_vga_port_emu.sv
`timescale 1ns/1ps
module test_vga_port_emu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] port_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0, wr_wide = 1'b0, rd_en = 1'b0;
  logic [7:0]  rd_data;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vga_port_emu i_vga_port_emu (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_data(wr_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .rd_en(rd_en), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read and compare
    logic [15:0] addr;
    logic [7:0]  val;   // write data or expected read data
    logic [7:0]  req;   // requirement number for the message
  } vec_t;

  localparam int NV = 44;
  localparam vec_t TBL [NV] = '{
    '{2'd0,16'h03C2,8'h01,8'd8}, '{2'd1,16'h03CC,8'h01,8'd8},   // R8 misc
    '{2'd0,16'h03C4,8'h02,8'd7}, '{2'd0,16'h03C5,8'hAB,8'd7},   // R7 sequencer
    '{2'd1,16'h03C5,8'hAB,8'd7}, '{2'd1,16'h03C4,8'h02,8'd7},
    '{2'd0,16'h03CE,8'h08,8'd7}, '{2'd0,16'h03CF,8'h5A,8'd7},   // R7 last graphics entry
    '{2'd1,16'h03CF,8'h5A,8'd7},
    '{2'd0,16'h03CE,8'h09,8'd7}, '{2'd0,16'h03CF,8'h77,8'd7},   // R7 one past the end
    '{2'd1,16'h03CF,8'hFF,8'd7}, '{2'd1,16'h03CE,8'h09,8'd7},
    '{2'd0,16'h03D4,8'h18,8'd6}, '{2'd0,16'h03D5,8'hC3,8'd6},   // R6 CRTC open
    '{2'd1,16'h03D5,8'hC3,8'd6}, '{2'd1,16'h03D4,8'h18,8'd6},
    '{2'd0,16'h03C6,8'hF0,8'd8}, '{2'd1,16'h03C6,8'hF0,8'd8},   // R8 mask
    '{2'd0,16'h03C8,8'h02,8'd4}, '{2'd1,16'h03C8,8'h06,8'd4},   // R4 scale by 3
    '{2'd0,16'h03C9,8'h11,8'd5}, '{2'd0,16'h03C9,8'h22,8'd5},   // R5 palette fill
    '{2'd0,16'h03C9,8'h33,8'd5}, '{2'd1,16'h03C8,8'h09,8'd5},
    '{2'd0,16'h03C7,8'h02,8'd4}, '{2'd1,16'h03C7,8'h06,8'd4},
    '{2'd1,16'h03C9,8'h11,8'd5}, '{2'd1,16'h03C9,8'h22,8'd5},
    '{2'd1,16'h03C7,8'h08,8'd5},
    '{2'd0,16'h03C8,8'hFF,8'd4}, '{2'd1,16'h03C8,8'hFD,8'd4},   // R4 765 low byte
    '{2'd0,16'h03C9,8'hA1,8'd5}, '{2'd0,16'h03C9,8'hA2,8'd5},   // R5 up to the end
    '{2'd0,16'h03C9,8'hA3,8'd5}, '{2'd1,16'h03C8,8'h00,8'd5},
    '{2'd0,16'h03C9,8'h99,8'd5}, '{2'd1,16'h03C8,8'h00,8'd5},   // R5 parked at 768
    '{2'd0,16'h03C7,8'hFF,8'd4}, '{2'd1,16'h03C9,8'hA1,8'd5},
    '{2'd1,16'h03C9,8'hA2,8'd5}, '{2'd1,16'h03C9,8'hA3,8'd5},
    '{2'd1,16'h03C9,8'hFF,8'd5}, '{2'd1,16'h03C7,8'h00,8'd5}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    port_addr = a; wr_data = {8'h00, d}; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wrw(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    port_addr = a; wr_data = d; wr_en = 1'b1; wr_wide = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    port_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk($sformatf("%s port %03h", tag, a), rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R1 rd_data after reset", rd_data, 8'h00);
    rd(16'h03C0, 8'h00, "R1 attr index");
    rd(16'h03DA, 8'h00, "R1 status");             // status now 09, flip-flop 0
    rd(16'h03CC, 8'h00, "R1 misc");
    rd(16'h03C5, 8'h00, "R1 seq entry 0");
    rd(16'h03C7, 8'h00, "R1 read pointer");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].op == 2'd0) wr(TBL[i].addr, TBL[i].val);
      else rd(TBL[i].addr, TBL[i].val, $sformatf("R%0d table %0d", TBL[i].req, i));
    end

    // R3 status toggles, R2 flip-flop order
    rd(16'h03DA, 8'h09, "R3 second status read");
    wr(16'h03C0, 8'h03);
    wr(16'h03C0, 8'h7E);
    rd(16'h03C1, 8'h7E, "R2 entry via 3C1");
    rd(16'h03C0, 8'h03, "R2 index phase read");
    rd(16'h03C0, 8'h7E, "R2 data phase read");

    // R9 word write on 3C0: index byte, high byte to read-only 3C1 (R10)
    wrw(16'h03C0, 16'h5504);
    rd(16'h03C0, 8'h00, "R9 data phase after word write");
    rd(16'h03C1, 8'h00, "R10 3C1 write had no effect");

    // R2 out-of-range attribute index
    wr(16'h03C0, 8'h15);
    wr(16'h03C0, 8'h44);
    rd(16'h03C1, 8'hFF, "R2 index 21 reads FF");
    rd(16'h03DA, 8'h00, "R3 third status read");
    rd(16'h03C0, 8'h15, "R3 flip-flop cleared by status");
    rd(16'h03DA, 8'h09, "R3 fourth status read");
    wr(16'h03C0, 8'h02);
    rd(16'h03DA, 8'h00, "R3 fifth status read");
    rd(16'h03C0, 8'h02, "R3 clear mid-pair gives index");

    // R9 word writes to index/data pairs
    wrw(16'h03C4, 16'h9901);
    rd(16'h03C5, 8'h99, "R9 high byte to seq data");
    rd(16'h03C4, 8'h01, "R9 low byte to seq index");
    wrw(16'h03D4, 16'h4A03);
    rd(16'h03D5, 8'h4A, "R9 high byte to crtc data");

    // R6 CRTC gate closed
    wr(16'h03C2, 8'h00);
    wr(16'h03D4, 8'h05);
    wr(16'h03D5, 8'hEE);
    rd(16'h03D4, 8'hFF, "R6 closed index read");
    rd(16'h03D5, 8'hFF, "R6 closed data read");
    wr(16'h03C2, 8'h01);
    rd(16'h03D4, 8'h03, "R6 index kept while closed");
    rd(16'h03D5, 8'h4A, "R6 entry kept while closed");

    // R10 unimplemented ports
    rd(16'h03C2, 8'hFF, "R10 misc write port read");
    rd(16'h03C3, 8'hFF, "R10 3C3 read");
    rd(16'h03B4, 8'hFF, "R10 outside window");
    wr(16'h03CC, 8'h55);
    rd(16'h03CC, 8'h01, "R10 misc read port write ignored");

    // R11 read data holds
    rd(16'h03C6, 8'hF0, "R11 mask read");
    repeat (2) @(negedge clk);
    chk("R11 hold over idle", rd_data, 8'hF0);
    wr(16'h03C6, 8'h0F);
    chk("R11 hold over write", rd_data, 8'hF0);
    rd(16'h03C6, 8'h0F, "R11 new mask");

    // R1 reset in mid-run
    do_reset();
    chk("R1 rd_data after second reset", rd_data, 8'h00);
    rd(16'h03C6, 8'h00, "R1 mask cleared");
    rd(16'h03CC, 8'h00, "R1 misc cleared");
    rd(16'h03C4, 8'h00, "R1 seq index cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule